// File: doc/BRIEF.md
# Debug Mailbox

The block is a two-way word mailbox between an external debugger and the processor it controls. Each direction has one holding register with a full flag. The debugger writes words for the core and reads words that the core has posted. The core has a plain strobe interface: it posts a word on one side and takes a word on the other.

The debugger reaches the block through a small register window. A status word at one address reports both full flags and a fixed module version number. The data word at a second address is the mailbox itself. A debugger read of the data word consumes the posted word, so software must read it exactly once per posted word.

The debugger sends a word when the down flag is clear. It reads a word when the up flag is set. The core does the same in reverse, using its ready and valid outputs.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both full flags are clear, both holding registers read zero, and the status word reads as the version field alone.
- R2: The status word sits at address 4. Bits 31:28 hold the VERSION parameter. Bit 0 is the down flag (debugger word pending for the core). Bit 1 is the up flag (core word pending for the debugger). Bits 27:2 read as zero.
- R3: A debugger write to address 5 stores the word and sets the down flag on the next clock. `core_rdata_o` shows the stored word and `core_rx_valid_o` mirrors the down flag.
- R4: A core read (`core_rd_i`) with the down flag set clears it on the next clock. A core read with the flag clear has no effect, and `core_rdata_o` keeps the last word.
- R5: A debugger write to address 5 while the down flag is set replaces the held word and leaves the flag set.
- R6: A core write with the up flag clear stores the word and sets the up flag on the next clock. A debugger read of address 5 then returns that word.
- R7: While the up flag is set, `core_tx_ready_o` is 0 and a core write is dropped, leaving the held word unchanged.
- R8: A debugger read of address 5 with the up flag set clears the flag on the next clock. Further reads return the same stale word and leave the flag clear.
- R9: Debugger writes to address 4 or to any unmapped address change nothing. Reads of unmapped addresses return zero.
- R10: In one cycle, a debugger write together with a core read (down flag set) hands the old word to the core and keeps the new word with the flag set. A core write together with a debugger data read (up flag set) drops the core word and clears the up flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dbg_addr_i | input | ADDR_W | Debugger register address |
| dbg_wr_i | input | 1 | Debugger write strobe |
| dbg_rd_i | input | 1 | Debugger read strobe (consumes the data word at address 5) |
| dbg_wdata_i | input | DATA_W | Debugger write data |
| dbg_rdata_o | output | DATA_W | Debugger read data for the addressed register |
| core_wr_i | input | 1 | Core post strobe |
| core_wdata_i | input | DATA_W | Word posted by the core |
| core_tx_ready_o | output | 1 | Core may post (up flag clear) |
| core_rd_i | input | 1 | Core take strobe |
| core_rdata_o | output | DATA_W | Word held for the core |
| core_rx_valid_o | output | 1 | A debugger word is pending (down flag) |

## Verification
The bench builds the block with a 32-bit word and a 5-bit address. It overrides VERSION to 4'hB so that a version value fixed in the logic would show up against the parameter. With a 32-bit word the version field meets the flag bits in one status word, and bit patterns that reach bit 31 also test that the version field stays clear of data. The same-cycle collisions in both directions are driven on purpose, and a long random mix then runs against the cycle model.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_DATA = 2'd2
  } dbg_reg_e;

  localparam int VER_W = 4;
  localparam int DOWN_BIT = 0;
  localparam int UP_BIT = 1;

endpackage

// File: rtl/dbg_mb_slot.sv
module dbg_mb_slot #(
  parameter int W         = 32,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         put_i,
  input  logic [W-1:0] put_data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);

  logic         full_q;
  logic [W-1:0] data_q;
  logic         put_ok;

  // the policy for a put into a full slot is chosen per direction
  generate
    if (OVERWRITE) begin : g_replace
      assign put_ok = put_i;
    end else begin : g_drop
      assign put_ok = put_i & ~full_q;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= put_ok | (full_q & ~take_i);
      if (put_ok) data_q <= put_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

endmodule

// File: rtl/dbg_mb_regif.sv
module dbg_mb_regif
  import dbg_mailbox_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 5,
  parameter int          CTRL_ADDR = 4,
  parameter int          DATA_ADDR = 5,
  parameter logic [3:0]  VERSION   = 4'd6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              down_full_i,
  input  logic              up_full_i,
  input  logic [DATA_W-1:0] up_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              put_down_o,
  output logic              pop_up_o
);

  function automatic dbg_reg_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(CTRL_ADDR)) return REG_CTRL;
    if (a == ADDR_W'(DATA_ADDR)) return REG_DATA;
    return REG_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic dn, input logic up);
    logic [DATA_W-1:0] v;
    v = '0;
    v[DATA_W-1 -: VER_W] = VERSION;
    v[DOWN_BIT] = dn;
    v[UP_BIT]   = up;
    return v;
  endfunction

  dbg_reg_e sel;

  always_comb begin
    sel = decode(addr_i);
    unique case (sel)
      REG_CTRL: rdata_o = pack_status(down_full_i, up_full_i);
      REG_DATA: rdata_o = up_word_i;
      default:  rdata_o = '0;
    endcase
  end

  // status writes have no writable bits, so only the data window acts
  assign put_down_o = wr_i & (sel == REG_DATA);
  assign pop_up_o   = rd_i & (sel == REG_DATA);

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int         DATA_W    = 32,
  parameter int         ADDR_W    = 5,
  parameter int         CTRL_ADDR = 4,
  parameter int         DATA_ADDR = 5,
  parameter logic [3:0] VERSION   = 4'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  input  logic              dbg_wr_i,
  input  logic              dbg_rd_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  input  logic              core_wr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic              core_tx_ready_o,
  input  logic              core_rd_i,
  output logic [DATA_W-1:0] core_rdata_o,
  output logic              core_rx_valid_o
);

  // named events, also used by the bound checker
  logic              dbg_put_down;
  logic              dbg_pop_up;
  logic              core_put_up;
  logic              core_take_down;
  logic              down_full;
  logic              up_full;
  logic              up_drop;
  logic [DATA_W-1:0] down_word;
  logic [DATA_W-1:0] up_word;

  assign core_put_up    = core_wr_i;
  assign core_take_down = core_rd_i;
  assign up_drop        = core_put_up & up_full;

  dbg_mb_regif #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .VERSION  (VERSION)
  ) regif_i (
    .addr_i     (dbg_addr_i),
    .wr_i       (dbg_wr_i),
    .rd_i       (dbg_rd_i),
    .down_full_i(down_full),
    .up_full_i  (up_full),
    .up_word_i  (up_word),
    .rdata_o    (dbg_rdata_o),
    .put_down_o (dbg_put_down),
    .pop_up_o   (dbg_pop_up)
  );

  // debugger to core: a new word replaces a pending one
  dbg_mb_slot #(.W(DATA_W), .OVERWRITE(1'b1)) down_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .put_i     (dbg_put_down),
    .put_data_i(dbg_wdata_i),
    .take_i    (core_take_down),
    .full_o    (down_full),
    .data_o    (down_word)
  );

  // core to debugger: a word posted into a full slot is lost
  dbg_mb_slot #(.W(DATA_W), .OVERWRITE(1'b0)) up_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .put_i     (core_put_up),
    .put_data_i(core_wdata_i),
    .take_i    (dbg_pop_up),
    .full_o    (up_full),
    .data_o    (up_word)
  );

  assign core_rdata_o    = down_word;
  assign core_rx_valid_o = down_full;
  assign core_tx_ready_o = ~up_full;

endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbg_put_down,
  input logic              dbg_pop_up,
  input logic              core_put_up,
  input logic              core_take_down,
  input logic              down_full,
  input logic              up_full,
  input logic              up_drop,
  input logic [DATA_W-1:0] down_word,
  input logic [DATA_W-1:0] up_word,
  input logic [DATA_W-1:0] dbg_wdata_i,
  input logic [DATA_W-1:0] core_wdata_i
);

  a_r3_put_sets_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_put_down |=> down_full && down_word == $past(dbg_wdata_i));

  a_r4_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_take_down && !dbg_put_down |=> !down_full);

  a_r4_idle_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_take_down && !down_full && !dbg_put_down |=> $stable(down_word));

  a_r5_keep_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_put_down && down_full |=> down_full);

  a_r6_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_put_up && !up_full |=> up_full && up_word == $past(core_wdata_i));

  a_r7_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_drop |=> $stable(up_word));

  a_r8_pop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_pop_up && up_full |=> !up_full);

endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dbg_put_down  (dbg_put_down),
  .dbg_pop_up    (dbg_pop_up),
  .core_put_up   (core_put_up),
  .core_take_down(core_take_down),
  .down_full     (down_full),
  .up_full       (up_full),
  .up_drop       (up_drop),
  .down_word     (down_word),
  .up_word       (up_word),
  .dbg_wdata_i   (dbg_wdata_i),
  .core_wdata_i  (core_wdata_i)
);

// File: tb/dbg_mailbox_tb_top.sv
module dbg_mailbox_tb_top;

  localparam int         CLK_PERIOD = 10;
  localparam int         DW  = 32;
  localparam int         AW  = 5;
  localparam logic [3:0] VER = 4'hB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] dbg_addr = '0;
  logic          dbg_wr = 1'b0, dbg_rd = 1'b0;
  logic [DW-1:0] dbg_wdata = '0;
  logic [DW-1:0] dbg_rdata;
  logic          core_wr = 1'b0, core_rd = 1'b0;
  logic [DW-1:0] core_wdata = '0;
  logic          core_ready, core_valid;
  logic [DW-1:0] core_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference state
  bit            m_dn, m_up;
  logic [DW-1:0] m_dn_word, m_up_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_mailbox #(.DATA_W(DW), .ADDR_W(AW), .VERSION(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .dbg_addr_i(dbg_addr), .dbg_wr_i(dbg_wr), .dbg_rd_i(dbg_rd),
    .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
    .core_wr_i(core_wr), .core_wdata_i(core_wdata), .core_tx_ready_o(core_ready),
    .core_rd_i(core_rd), .core_rdata_o(core_rdata), .core_rx_valid_o(core_valid)
  );

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_dbg(input logic [AW-1:0] a);
    logic [DW-1:0] s;
    if (a == 5'd4) begin
      s = {VER, 28'd0};
      s[0] = m_dn;
      s[1] = m_up;
      return s;
    end
    if (a == 5'd5) return m_up_word;
    return '0;
  endfunction

  // one cycle: drive at the falling edge, compare, update the model at the rising edge
  task automatic op(input string tag, input logic [AW-1:0] a, input bit dw, input bit dr,
                    input logic [DW-1:0] wd, input bit cw, input logic [DW-1:0] cwd,
                    input bit cr);
    @(negedge clk);
    dbg_addr = a; dbg_wr = dw; dbg_rd = dr; dbg_wdata = wd;
    core_wr = cw; core_wdata = cwd; core_rd = cr;
    #1;
    check(tag, "dbg_rdata", dbg_rdata, exp_dbg(a));
    check(tag, "core_rdata", core_rdata, m_dn_word);
    check(tag, "rx_valid", {31'd0, core_valid}, {31'd0, m_dn});
    check(tag, "tx_ready", {31'd0, core_ready}, {31'd0, !m_up});
    @(posedge clk);
    if (dw && a == 5'd5) begin
      m_dn = 1'b1; m_dn_word = wd;
    end else if (cr) begin
      m_dn = 1'b0;
    end
    if (cw && !m_up) begin
      m_up = 1'b1; m_up_word = cwd;
    end else if (dr && a == 5'd5) begin
      m_up = 1'b0;
    end
  endtask

  task automatic idle(input string tag, input logic [AW-1:0] a);
    op(tag, a, 0, 0, '0, 0, '0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_dn = 0; m_up = 0; m_dn_word = '0; m_up_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R2 status layout
    idle("R1", 5'd4);
    idle("R1", 5'd5);
    // R3 debugger sends a word
    op("R3", 5'd5, 1, 0, 32'hA5A5_0001, 0, '0, 0);
    idle("R2", 5'd4);
    // R5 replace a pending word
    op("R5", 5'd5, 1, 0, 32'h8000_1234, 0, '0, 0);
    idle("R5", 5'd4);
    // R4 core takes, then takes again with nothing pending
    op("R4", 5'd4, 0, 0, '0, 0, '0, 1);
    op("R4", 5'd4, 0, 0, '0, 0, '0, 1);
    idle("R4", 5'd4);
    // R6 core posts a word
    op("R6", 5'd4, 0, 0, '0, 1, 32'hDEAD_BEEF, 0);
    idle("R6", 5'd5);
    // R7 second post is dropped
    op("R7", 5'd5, 0, 0, '0, 1, 32'h5555_5555, 0);
    idle("R7", 5'd5);
    // R8 pop then stale reads
    op("R8", 5'd5, 0, 1, '0, 0, '0, 0);
    op("R8", 5'd5, 0, 1, '0, 0, '0, 0);
    idle("R8", 5'd4);
    // R9 writes to status and unmapped addresses, unmapped reads
    op("R9", 5'd4, 1, 0, 32'hFFFF_FFFF, 0, '0, 0);
    op("R9", 5'd7, 1, 1, 32'h1357_9BDF, 0, '0, 0);
    idle("R9", 5'd0);
    idle("R9", 5'd4);
    idle("R9", 5'd31);
    // R10 same-cycle collisions in each direction
    op("R10", 5'd5, 1, 0, 32'h0000_00AA, 0, '0, 0);
    op("R10", 5'd5, 1, 0, 32'h0000_00BB, 0, '0, 1);
    idle("R10", 5'd4);
    op("R10", 5'd4, 0, 0, '0, 1, 32'hC0DE_0001, 0);
    op("R10", 5'd5, 0, 1, '0, 1, 32'hC0DE_0002, 0);
    idle("R10", 5'd4);
    idle("R10", 5'd5);
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, 31))
                                      : AW'($urandom_range(4, 5));
      op("R3", a, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom(),
         $urandom_range(0, 2) == 0, $urandom(), $urandom_range(0, 2) == 0);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule